// File: doc/BRIEF.md
# Hardware prefetch request queue

This block holds prefetch candidates for a cache in a small, ordered queue. The cache reports each demand miss to it. The block turns the miss address into a block address and cancels any queued prefetch of that block. In serial-squash mode it also drops the newest queued work that would not be ready before the miss. It then records the miss time and thread as the base for the candidates that follow.

A separate address generator offers candidates one per cycle over a valid/ready handshake. A candidate is filtered against the miss-status registers and the queue itself. When the push-check option is set, it is also filtered against the cache. Both of these outside structures answer through same-cycle lookup ports. A surviving candidate goes to the tail of the queue, and when the queue is full the head is dropped to make room. A bus request toward the memory side stays high while work is queued. When the memory side asks to issue, the block hands out the oldest entry. Saturating event counters record what happened to every candidate.

Top module: `prefetch_queue`

## Requirements
- R1: A miss is ignored when `miss_uncached` is 1. It is also ignored when `miss_ifetch` is 1 and `cfg_data_only` is 1. An ignored miss removes no entry, squashes nothing, leaves the base time unchanged and does not block candidates.
- R2: Block addresses are formed by clearing the low log2(BLK_BYTES) address bits. Every comparison and every issued address (`iss_addr`) uses this block-aligned form.
- R3: A qualifying miss removes the queued entry whose block address equals the miss block, if there is one. Each such removal adds one to `cnt_cancelled`.
- R4: When `cfg_serial_squash` is 1, a qualifying miss also removes entries from the tail, after the R3 removal. Removal continues while the tail entry's ready time is greater than or equal to `miss_time`. Each entry removed this way adds one to `cnt_squashed`.
- R5: A queued candidate takes a ready time equal to the base time plus `cand_delay`, modulo 2^16. The base time is the `miss_time` of the latest qualifying miss. The candidate's thread id is that miss's `miss_tid`. An issued entry presents these values on `iss_time` and `iss_tid`.
- R6: Every accepted candidate adds one to `cnt_identified`. The candidate is discarded if `push_mshr_hit` is 1, or if `push_cache_hit` is 1 while `cfg_push_check` is 1. It is also discarded if its block is already queued, and only this last case adds one to `cnt_dedup`.
- R7: When a surviving candidate arrives and DEPTH entries are already queued, the head entry is dropped and `cnt_evicted` goes up by one. The candidate is then appended at the tail.
- R8: `bus_req` rises in the cycle after each insertion, and `bus_time` then carries the inserted ready time. `bus_req` falls after any operation that leaves the queue empty, and it is 0 after reset.
- R9: An issue request that is served pops the head. If `cfg_push_check` is 0 and `iss_cache_hit` is 1, the popped head is discarded and `iss_valid` stays 0 for that cycle. Otherwise `iss_valid` is 1 in the same cycle with the head's fields, and `cnt_issued` goes up by one. A request on an empty queue gives `iss_valid` = 0.
- R10: Operations take priority in this order: qualifying miss, then candidate, then issue. `cand_ready` is 0 exactly in qualifying-miss cycles. An issue request is served only when there is no qualifying miss and `cand_valid` is 0.
- R11: All counters are CNT_W bits wide, reset to 0 and saturate at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch misses |
| cfg_serial_squash | input | 1 | Enable tail squash on a miss |
| cfg_push_check | input | 1 | Filter candidates by cache hit at insertion instead of at issue |
| miss_valid | input | 1 | Demand miss reported this cycle |
| miss_addr | input | 32 | Miss byte address |
| miss_time | input | 16 | Miss time |
| miss_tid | input | 2 | Thread of the miss |
| miss_uncached | input | 1 | Miss is uncacheable |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate accepted this cycle when valid |
| cand_addr | input | 32 | Candidate byte address |
| cand_delay | input | DELAY_W | Candidate delay after the base time |
| push_cache_addr | output | 32 | Cache lookup address for the candidate |
| push_cache_hit | input | 1 | Cache lookup result for the candidate |
| push_mshr_addr | output | 32 | Miss-queue lookup address for the candidate |
| push_mshr_hit | input | 1 | Miss-queue lookup result |
| iss_req | input | 1 | Memory side asks for a prefetch |
| iss_valid | output | 1 | Prefetch issued this cycle |
| iss_addr | output | 32 | Issued block address |
| iss_time | output | 16 | Issued ready time |
| iss_tid | output | 2 | Issued thread id |
| iss_cache_addr | output | 32 | Cache lookup address for the head |
| iss_cache_hit | input | 1 | Cache lookup result for the head |
| bus_req | output | 1 | Memory-side bus request |
| bus_time | output | 16 | Ready time of the latest insertion |
| cnt_identified | output | CNT_W | Accepted candidates |
| cnt_dedup | output | CNT_W | Candidates already queued |
| cnt_evicted | output | CNT_W | Heads dropped when full |
| cnt_squashed | output | CNT_W | Entries squashed by serial mode |
| cnt_cancelled | output | CNT_W | Entries cancelled by a matching miss |
| cnt_issued | output | CNT_W | Prefetches issued |

## Verification
The bench builds the block with DEPTH=4, BLK_BYTES=16 and CNT_W=6. The small depth makes the queue fill often, so head eviction and the dedup search over a full array come up many times. The six-bit counters reach saturation within the run, and several counters are checked while pinned at their limit. The 16-byte block size lets random addresses with low offset bits collide on the same block, which exercises cancellation, dedup and block alignment.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int PQ_ADDR_W = 32;
    localparam int PQ_TIME_W = 16;
    localparam int PQ_TID_W  = 2;

    typedef enum logic [1:0] {
        Q_IDLE = 2'd0,
        Q_MISS = 2'd1,
        Q_PUSH = 2'd2,
        Q_POP  = 2'd3
    } q_op_e;

    typedef struct packed {
        logic                 valid;
        logic [PQ_ADDR_W-1:0] addr;
        logic [PQ_TIME_W-1:0] rdy_time;
        logic [PQ_TID_W-1:0]  tid;
    } pfq_entry_t;

    function automatic logic [PQ_ADDR_W-1:0] blk_of(
        input logic [PQ_ADDR_W-1:0] a,
        input int unsigned          off
    );
        logic [PQ_ADDR_W-1:0] mask;
        mask = (PQ_ADDR_W'(1) << off) - PQ_ADDR_W'(1);
        return a & ~mask;
    endfunction

endpackage

// File: rtl/pfq_store.sv
module pfq_store
    import pfq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  q_op_e          op,
    input  logic [DEPTH-1:0] keep,
    input  pfq_entry_t     push_ent,
    output pfq_entry_t     ents [DEPTH],
    output logic [CW-1:0]  count,
    output logic [CW-1:0]  count_nxt
);

    pfq_entry_t nxt [DEPTH];
    int         slot;

    always_comb begin
        nxt       = ents;
        count_nxt = count;
        slot      = 0;
        case (op)
            Q_MISS: begin
                for (int k = 0; k < DEPTH; k++) nxt[k] = '0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (keep[i]) begin
                        for (int k = 0; k < DEPTH; k++) begin
                            if (k == slot) nxt[k] = ents[i];
                        end
                        slot = slot + 1;
                    end
                end
                count_nxt = CW'(slot);
            end
            Q_PUSH: begin
                if (count == CW'(DEPTH)) begin
                    for (int i = 0; i < DEPTH - 1; i++) nxt[i] = ents[i+1];
                    nxt[DEPTH-1] = push_ent;
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CW'(i) == count) nxt[i] = push_ent;
                    end
                    count_nxt = count + CW'(1);
                end
            end
            Q_POP: begin
                for (int i = 0; i < DEPTH - 1; i++) nxt[i] = ents[i+1];
                nxt[DEPTH-1] = '0;
                count_nxt    = count - CW'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
            count <= '0;
        end else begin
            ents  <= nxt;
            count <= count_nxt;
        end
    end

endmodule

// File: rtl/pfq_miss_filter.sv
module pfq_miss_filter
    import pfq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  pfq_entry_t            ents [DEPTH],
    input  logic [PQ_ADDR_W-1:0]  miss_blk,
    input  logic [PQ_TIME_W-1:0]  miss_time,
    input  logic                  serial_en,
    output logic [DEPTH-1:0]      keep,
    output logic                  cancel_hit,
    output logic [CW-1:0]         squash_n
);

    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] late;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g]  = ents[g].valid && (ents[g].addr == miss_blk);
        assign late[g] = (ents[g].rdy_time >= miss_time);
    end

    assign cancel_hit = |hit;

    logic all_late;
    logic surv;
    logic kill;

    always_comb begin
        all_late = 1'b1;
        squash_n = '0;
        keep     = '0;
        surv     = 1'b0;
        kill     = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            surv     = ents[i].valid && !hit[i];
            all_late = all_late && (!surv || late[i]);
            kill     = serial_en && surv && all_late;
            keep[i]  = surv && !kill;
            if (kill) squash_n = squash_n + CW'(1);
        end
    end

endmodule

// File: rtl/pfq_sat_counter.sv
module pfq_sat_counter #(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  value
);

    logic [W:0] sum;

    assign sum = (W+1)'(value) + (W+1)'(amt);

    always_ff @(posedge clk) begin
        if (rst)         value <= '0;
        else if (sum[W]) value <= '1;
        else             value <= sum[W-1:0];
    end

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int BLK_BYTES = 64,
    parameter int DELAY_W   = 8,
    parameter int CNT_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_data_only,
    input  logic                 cfg_serial_squash,
    input  logic                 cfg_push_check,
    input  logic                 miss_valid,
    input  logic [PQ_ADDR_W-1:0] miss_addr,
    input  logic [PQ_TIME_W-1:0] miss_time,
    input  logic [PQ_TID_W-1:0]  miss_tid,
    input  logic                 miss_uncached,
    input  logic                 miss_ifetch,
    input  logic                 cand_valid,
    output logic                 cand_ready,
    input  logic [PQ_ADDR_W-1:0] cand_addr,
    input  logic [DELAY_W-1:0]   cand_delay,
    output logic [PQ_ADDR_W-1:0] push_cache_addr,
    input  logic                 push_cache_hit,
    output logic [PQ_ADDR_W-1:0] push_mshr_addr,
    input  logic                 push_mshr_hit,
    input  logic                 iss_req,
    output logic                 iss_valid,
    output logic [PQ_ADDR_W-1:0] iss_addr,
    output logic [PQ_TIME_W-1:0] iss_time,
    output logic [PQ_TID_W-1:0]  iss_tid,
    output logic [PQ_ADDR_W-1:0] iss_cache_addr,
    input  logic                 iss_cache_hit,
    output logic                 bus_req,
    output logic [PQ_TIME_W-1:0] bus_time,
    output logic [CNT_W-1:0]     cnt_identified,
    output logic [CNT_W-1:0]     cnt_dedup,
    output logic [CNT_W-1:0]     cnt_evicted,
    output logic [CNT_W-1:0]     cnt_squashed,
    output logic [CNT_W-1:0]     cnt_cancelled,
    output logic [CNT_W-1:0]     cnt_issued
);

    localparam int OFF  = $clog2(BLK_BYTES);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int NCNT = 6;

    // Queue state
    pfq_entry_t       q_ents [DEPTH];
    logic [CW-1:0]    q_count;
    logic [CW-1:0]    q_count_nxt;
    q_op_e            q_op;
    pfq_entry_t       push_ent;
    logic [DEPTH-1:0] keep;
    logic             cancel_hit;
    logic [CW-1:0]    squash_n;

    // Base of the latest qualifying miss
    logic [PQ_TIME_W-1:0] base_time;
    logic [PQ_TID_W-1:0]  base_tid;

    // Miss qualification and block forming
    logic                 miss_qual;
    logic [PQ_ADDR_W-1:0] miss_blk;
    logic [PQ_ADDR_W-1:0] cand_blk;

    assign miss_qual = miss_valid && !miss_uncached && !(miss_ifetch && cfg_data_only);
    assign miss_blk  = blk_of(miss_addr, OFF);
    assign cand_blk  = blk_of(cand_addr, OFF);

    // Candidate path
    logic             cand_fire;
    logic [DEPTH-1:0] in_q_vec;
    logic             in_q;
    logic             ext_drop;
    logic             cand_ok;
    logic             cand_dup;
    logic             q_full;
    logic             evict;

    for (genvar g = 0; g < DEPTH; g++) begin : g_dup
        assign in_q_vec[g] = q_ents[g].valid && (q_ents[g].addr == cand_blk);
    end

    assign in_q            = |in_q_vec;
    assign cand_ready      = !miss_qual;
    assign cand_fire       = cand_valid && !miss_qual;
    assign push_cache_addr = cand_blk;
    assign push_mshr_addr  = cand_blk;
    assign ext_drop        = (cfg_push_check && push_cache_hit) || push_mshr_hit;
    assign cand_ok         = cand_fire && !ext_drop && !in_q;
    assign cand_dup        = cand_fire && !ext_drop && in_q;
    assign q_full          = (q_count == CW'(DEPTH));
    assign evict           = cand_ok && q_full;

    always_comb begin
        push_ent          = '0;
        push_ent.valid    = 1'b1;
        push_ent.addr     = cand_blk;
        push_ent.rdy_time = base_time + PQ_TIME_W'(cand_delay);
        push_ent.tid      = base_tid;
    end

    // Issue path
    logic       iss_serve;
    logic       iss_skip;
    pfq_entry_t head;

    assign head           = q_ents[0];
    assign iss_cache_addr = head.addr;
    assign iss_serve      = iss_req && !miss_qual && !cand_valid && (q_count != '0);
    assign iss_skip       = !cfg_push_check && iss_cache_hit;
    assign iss_valid      = iss_serve && !iss_skip;
    assign iss_addr       = head.addr;
    assign iss_time       = head.rdy_time;
    assign iss_tid        = head.tid;

    // Operation select: miss, then candidate, then issue
    always_comb begin
        if (miss_qual)      q_op = Q_MISS;
        else if (cand_ok)   q_op = Q_PUSH;
        else if (iss_serve) q_op = Q_POP;
        else                q_op = Q_IDLE;
    end

    pfq_miss_filter #(.DEPTH(DEPTH)) u_filter (
        .ents       (q_ents),
        .miss_blk   (miss_blk),
        .miss_time  (miss_time),
        .serial_en  (cfg_serial_squash),
        .keep       (keep),
        .cancel_hit (cancel_hit),
        .squash_n   (squash_n)
    );

    pfq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (q_op),
        .keep      (keep),
        .push_ent  (push_ent),
        .ents      (q_ents),
        .count     (q_count),
        .count_nxt (q_count_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_time <= '0;
            base_tid  <= '0;
            bus_req   <= 1'b0;
            bus_time  <= '0;
        end else begin
            if (miss_qual) begin
                base_time <= miss_time;
                base_tid  <= miss_tid;
            end
            if (cand_ok) begin
                bus_req  <= 1'b1;
                bus_time <= push_ent.rdy_time;
            end else if (q_count_nxt == '0) begin
                bus_req  <= 1'b0;
            end
        end
    end

    // Event counters
    logic [CW-1:0]    cnt_amt [NCNT];
    logic [CNT_W-1:0] cnt_val [NCNT];

    assign cnt_amt[0] = CW'(cand_fire);
    assign cnt_amt[1] = CW'(cand_dup);
    assign cnt_amt[2] = CW'(evict);
    assign cnt_amt[3] = miss_qual ? squash_n : '0;
    assign cnt_amt[4] = CW'(miss_qual && cancel_hit);
    assign cnt_amt[5] = CW'(iss_valid);

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        pfq_sat_counter #(.W(CNT_W), .AW(CW)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .amt   (cnt_amt[c]),
            .value (cnt_val[c])
        );
    end

    assign cnt_identified = cnt_val[0];
    assign cnt_dedup      = cnt_val[1];
    assign cnt_evicted    = cnt_val[2];
    assign cnt_squashed   = cnt_val[3];
    assign cnt_cancelled  = cnt_val[4];
    assign cnt_issued     = cnt_val[5];

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker
    import pfq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int BLK_BYTES = 64,
    parameter int CNT_W     = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_data_only,
    input logic                 miss_valid,
    input logic                 miss_uncached,
    input logic                 miss_ifetch,
    input logic                 iss_req,
    input logic                 iss_valid,
    input logic [PQ_ADDR_W-1:0] iss_addr,
    input logic                 bus_req,
    input logic [CW-1:0]        count,
    input logic [CNT_W-1:0]     cnt_cancelled,
    input logic [CNT_W-1:0]     cnt_squashed,
    input logic [CNT_W-1:0]     cnt_issued
);

    localparam logic [PQ_ADDR_W-1:0] OFF_MASK = PQ_ADDR_W'(BLK_BYTES - 1);

    a_r1_unqualified_miss_inert: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && (miss_uncached || (miss_ifetch && cfg_data_only)))
        |=> ($stable(cnt_cancelled) && $stable(cnt_squashed)));

    a_r4_squash_needs_miss: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |=> $stable(cnt_squashed));

    a_r9_issue_needs_req: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> iss_req);

    a_r9_empty_no_issue: assert property (@(posedge clk) disable iff (rst)
        (iss_req && (count == '0)) |-> !iss_valid);

    a_r8_bus_low_when_empty: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !bus_req);

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r2_issue_aligned: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> ((iss_addr & OFF_MASK) == '0));

    a_r11_issued_step: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> ((cnt_issued == CNT_W'($past(cnt_issued) + CNT_W'(1)))
                       || (&$past(cnt_issued))));

endmodule

bind prefetch_queue pfq_checker #(
    .DEPTH     (DEPTH),
    .BLK_BYTES (BLK_BYTES),
    .CNT_W     (CNT_W)
) u_pfq_checker (
    .clk           (clk),
    .rst           (rst),
    .cfg_data_only (cfg_data_only),
    .miss_valid    (miss_valid),
    .miss_uncached (miss_uncached),
    .miss_ifetch   (miss_ifetch),
    .iss_req       (iss_req),
    .iss_valid     (iss_valid),
    .iss_addr      (iss_addr),
    .bus_req       (bus_req),
    .count         (q_count),
    .cnt_cancelled (cnt_cancelled),
    .cnt_squashed  (cnt_squashed),
    .cnt_issued    (cnt_issued)
);

// File: tb/tb_prefetch_queue.sv
module tb_prefetch_queue;

    localparam int DEPTH   = 4;
    localparam int BLK     = 16;
    localparam int DELAY_W = 8;
    localparam int CNT_W   = 6;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_data_only = 1'b0, cfg_serial_squash = 1'b0, cfg_push_check = 1'b1;
    logic        miss_valid = 1'b0, miss_uncached = 1'b0, miss_ifetch = 1'b0;
    logic [31:0] miss_addr = '0;
    logic [15:0] miss_time = '0;
    logic [1:0]  miss_tid = '0;
    logic        cand_valid = 1'b0;
    logic [31:0] cand_addr = '0;
    logic [DELAY_W-1:0] cand_delay = '0;
    logic        iss_req = 1'b0;
    logic        cand_ready, iss_valid, bus_req;
    logic [31:0] push_cache_addr, push_mshr_addr, iss_cache_addr, iss_addr;
    logic        push_cache_hit, push_mshr_hit, iss_cache_hit;
    logic [15:0] iss_time, bus_time;
    logic [1:0]  iss_tid;
    logic [CNT_W-1:0] cnt_identified, cnt_dedup, cnt_evicted, cnt_squashed, cnt_cancelled, cnt_issued;

    always #10 clk = ~clk;

    // Outside structures: fixed rules on address bits 13:12
    function automatic bit in_cache(logic [31:0] a); return a[13:12] == 2'b11; endfunction
    function automatic bit in_mshr(logic [31:0] a);  return a[13:12] == 2'b10; endfunction

    assign push_cache_hit = in_cache(push_cache_addr);
    assign push_mshr_hit  = in_mshr(push_mshr_addr);
    assign iss_cache_hit  = in_cache(iss_cache_addr);

    prefetch_queue #(.DEPTH(DEPTH), .BLK_BYTES(BLK), .DELAY_W(DELAY_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .cfg_data_only(cfg_data_only), .cfg_serial_squash(cfg_serial_squash),
        .cfg_push_check(cfg_push_check), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_time(miss_time), .miss_tid(miss_tid), .miss_uncached(miss_uncached),
        .miss_ifetch(miss_ifetch), .cand_valid(cand_valid), .cand_ready(cand_ready),
        .cand_addr(cand_addr), .cand_delay(cand_delay), .push_cache_addr(push_cache_addr),
        .push_cache_hit(push_cache_hit), .push_mshr_addr(push_mshr_addr), .push_mshr_hit(push_mshr_hit),
        .iss_req(iss_req), .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_time(iss_time),
        .iss_tid(iss_tid), .iss_cache_addr(iss_cache_addr), .iss_cache_hit(iss_cache_hit),
        .bus_req(bus_req), .bus_time(bus_time), .cnt_identified(cnt_identified),
        .cnt_dedup(cnt_dedup), .cnt_evicted(cnt_evicted), .cnt_squashed(cnt_squashed),
        .cnt_cancelled(cnt_cancelled), .cnt_issued(cnt_issued)
    );

    // Reference model
    typedef struct { logic [31:0] a; logic [15:0] t; logic [1:0] id; } m_ent_t;
    m_ent_t m_q[$];
    logic [15:0] m_base_t;
    logic [1:0]  m_base_id;
    bit          m_bus;
    logic [15:0] m_bus_t;
    int m_ident, m_dedup, m_evict, m_squash, m_cancel, m_issued;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    function automatic logic [31:0] blk(logic [31:0] a); return a & ~32'(BLK - 1); endfunction
    function automatic int sat(int v, int n); return (v + n > CMAX) ? CMAX : v + n; endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_qual();
        return miss_valid && !miss_uncached && !(miss_ifetch && cfg_data_only);
    endfunction

    task automatic model_reset();
        m_q.delete();
        m_base_t = '0; m_base_id = '0; m_bus = 0; m_bus_t = '0;
        m_ident = 0; m_dedup = 0; m_evict = 0; m_squash = 0; m_cancel = 0; m_issued = 0;
    endtask

    task automatic check_comb();
        bit e_iv;
        e_iv = iss_req && !m_qual() && !cand_valid && (m_q.size() > 0)
               && !(!cfg_push_check && in_cache(m_q[0].a));
        chk("R10 cand_ready", cand_ready, !m_qual());
        chk("R9 iss_valid", iss_valid, e_iv);
        if (e_iv) begin
            chk("R2 iss_addr", iss_addr, m_q[0].a);
            chk("R5 iss_time", iss_time, m_q[0].t);
            chk("R5 iss_tid", iss_tid, m_q[0].id);
        end
    endtask

    task automatic model_step();
        logic [31:0] a;
        logic [15:0] rt;
        bit found;
        if (m_qual()) begin
            a = blk(miss_addr);
            for (int i = 0; i < m_q.size(); i++) begin
                if (m_q[i].a == a) begin m_q.delete(i); m_cancel = sat(m_cancel, 1); break; end
            end
            if (cfg_serial_squash) begin
                while (m_q.size() > 0 && m_q[m_q.size()-1].t >= miss_time) begin
                    void'(m_q.pop_back());
                    m_squash = sat(m_squash, 1);
                end
            end
            m_base_t = miss_time; m_base_id = miss_tid;
            if (m_q.size() == 0) m_bus = 0;
        end else if (cand_valid) begin
            m_ident = sat(m_ident, 1);
            a  = blk(cand_addr);
            rt = m_base_t + 16'(cand_delay);
            found = 0;
            foreach (m_q[i]) if (m_q[i].a == a) found = 1;
            if ((cfg_push_check && in_cache(a)) || in_mshr(a)) begin
            end else if (found) begin
                m_dedup = sat(m_dedup, 1);
            end else begin
                if (m_q.size() == DEPTH) begin void'(m_q.pop_front()); m_evict = sat(m_evict, 1); end
                m_q.push_back('{a: a, t: rt, id: m_base_id});
                m_bus = 1; m_bus_t = rt;
            end
        end else if (iss_req && m_q.size() > 0) begin
            m_ent_t h;
            h = m_q.pop_front();
            if (cfg_push_check || !in_cache(h.a)) m_issued = sat(m_issued, 1);
            if (m_q.size() == 0) m_bus = 0;
        end
    endtask

    task automatic check_regs();
        chk("R8 bus_req", bus_req, m_bus);
        if (m_bus) chk("R8 bus_time", bus_time, m_bus_t);
        chk("R6 cnt_identified", cnt_identified, m_ident);
        chk("R6 cnt_dedup", cnt_dedup, m_dedup);
        chk("R7 cnt_evicted", cnt_evicted, m_evict);
        chk("R4 cnt_squashed", cnt_squashed, m_squash);
        chk("R3 R1 cnt_cancelled", cnt_cancelled, m_cancel);
        chk("R9 R11 cnt_issued", cnt_issued, m_issued);
    endtask

    // Inputs are set at the falling edge; outputs sampled mid-phase
    task automatic cycle();
        #5;
        check_comb();
        model_step();
        @(posedge clk);
        #5;
        check_regs();
        @(negedge clk);
    endtask

    task automatic idle();
        miss_valid = 0; miss_uncached = 0; miss_ifetch = 0; cand_valid = 0; iss_req = 0;
    endtask

    task automatic do_miss(logic [31:0] a, logic [15:0] t, logic [1:0] id, bit unc, bit ifx);
        idle();
        miss_valid = 1; miss_addr = a; miss_time = t; miss_tid = id; miss_uncached = unc; miss_ifetch = ifx;
        cycle();
    endtask

    task automatic do_cand(logic [31:0] a, int d);
        idle();
        cand_valid = 1; cand_addr = a; cand_delay = DELAY_W'(d);
        cycle();
    endtask

    task automatic do_issue();
        idle();
        iss_req = 1;
        cycle();
    endtask

    function automatic logic [31:0] raddr();
        logic [31:0] r;
        r = $urandom;
        return {18'b0, r[1:0], 5'b0, r[4:2], r[8:5]};
    endfunction

    int base_val;

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // Reset state
        iss_req = 1;
        #5;
        chk("R9 reset iss_valid", iss_valid, 0);
        chk("R8 reset bus_req", bus_req, 0);
        chk("R11 reset cnt_identified", cnt_identified, 0);
        chk("R11 reset cnt_issued", cnt_issued, 0);
        @(negedge clk);
        idle();

        // R1 and R3 directed
        cfg_data_only = 1; cfg_serial_squash = 0; cfg_push_check = 1;
        do_miss(32'h100, 16'd100, 2'd1, 0, 0);
        do_cand(32'h50, 3);
        do_cand(32'h65, 5);
        do_miss(32'h55, 16'd150, 2'd2, 1, 0);
        do_miss(32'h52, 16'd150, 2'd2, 0, 1);
        chk("R1 ignored misses cancel nothing", cnt_cancelled, 0);
        chk("R1 ignored misses keep bus_req", bus_req, 1);
        cfg_data_only = 0;
        do_miss(32'h58, 16'd200, 2'd0, 0, 1);
        chk("R3 matching miss cancels", cnt_cancelled, 1);
        do_issue();
        chk("R9 oldest survivor issued", cnt_issued, 1);
        chk("R8 bus_req drops when empty", bus_req, 0);

        // R4 directed: base 200
        cfg_serial_squash = 1;
        do_cand(32'h100, 1);
        do_cand(32'h110, 9);
        do_cand(32'h120, 4);
        base_val = int'(cnt_squashed);
        do_miss(32'h300, 16'd204, 2'd3, 0, 0);
        chk("R4 tail squash count", int'(cnt_squashed) - base_val, 2);
        do_issue();
        chk("R8 empty after squash and issue", bus_req, 0);

        // R7 and R6 directed
        cfg_serial_squash = 0;
        for (int i = 0; i < 5; i++) do_cand(32'h400 + 32'(i * 16), i);
        chk("R7 one eviction on overflow", cnt_evicted, 1);
        do_cand(32'h418, 2);
        chk("R6 duplicate counted", cnt_dedup, 1);
        base_val = int'(cnt_identified);
        do_cand(32'h2400, 1);
        do_cand(32'h3400, 1);
        chk("R6 filtered candidates identified", int'(cnt_identified) - base_val, 2);
        chk("R6 filtered candidates not evicting", cnt_evicted, 1);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            if (n % 400 == 0) begin
                cfg_data_only = 1'($urandom); cfg_serial_squash = 1'($urandom); cfg_push_check = 1'($urandom);
            end
            idle();
            miss_valid    = ($urandom % 100) < 15;
            miss_uncached = ($urandom % 100) < 15;
            miss_ifetch   = ($urandom % 100) < 30;
            miss_addr     = raddr();
            miss_time     = 16'($urandom % 80);
            miss_tid      = 2'($urandom);
            cand_valid    = ($urandom % 100) < 45;
            cand_addr     = raddr();
            cand_delay    = DELAY_W'($urandom % 16);
            iss_req       = ($urandom % 100) < 50;
            cycle();
        end
        idle();
        chk("R11 identified counter saturated", cnt_identified, CMAX);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule